// File: doc/BRIEF.md
# Table-Driven Register Init Sequencer

After a start pulse, this block brings a register bank up on its own. It first opens two write-protected gates. For each gate it writes a key word and then reads the gate back until the readback equals exactly one. Next it reads a configuration word and derives a memory layout code from it. It then steps through an internal table of entries and issues each one on a simple memory-mapped master port with address, write data, write strobe, read strobe, read data and ready.

Most table entries are plain writes of a 32-bit value to a fixed base address plus an offset. Three other entry kinds control the walk:
- A delay entry idles the port for a number of microseconds, and that wait is repeated fifteen times.
- A substitution entry writes a value picked from the decoded layout. Before it writes, it reads a second register and merges two live bits from that register into the value.
- An end entry finishes the walk and raises a sticky done flag.

Top module: `init_seq`

## Requirements
- R1: After start, the block writes 0x1688A8A8 to the first gate address and reads that address until a readback equals exactly 0x00000001. Any other value, including 0x3, causes another read. It then does the same for the second gate address with key 0xFC600309. Only after the second gate reads back 0x1 does the block read the configuration address.
- R2: The layout comes from bits 3:2 of the configuration word. A field value of 0 or 1 gives the 512Mx16 layout, and bit 6 is ignored. A value of 2 gives 1Gx16 when bit 6 is 1 and 512Mx32 otherwise. A value of 3 gives 1Gx32.
- R3: Plain entries are written in table order. Each one goes to BASE_ADDR plus its 16-bit offset with its 32-bit value. When a plain write follows a plain write, the two acceptances are 2 plus the ready latency cycles apart.
- R4: A substitution entry writes 0xD89 for 1Gx16 and 0xC8D for 1Gx32. For any other layout it writes the value held in the entry.
- R5: Before a substitution write, the block reads the merge address. Merge bits 3:2 are shifted left by two and ORed into the written value, so they land on bits 5:4. No other merge bit has any effect.
- R6: During a delay entry of n microseconds, the port stays idle for exactly 15·n·CYC_PER_US cycles. The write that follows is accepted 15·n·CYC_PER_US + 3 + latency cycles after the previous write. When a substitution entry follows the delay, the offset is 15·n·CYC_PER_US + 4 + 2·latency, because of its merge read.
- R7: A request stays asserted, with its address and data stable, until the cycle in which ready is high. Read and write are never requested together.
- R8: The end entry raises done two cycles after the last write is accepted. Done stays high with the port idle until the next start pulse, which restarts the whole sequence.
- R9: A start pulse that arrives while the sequence is running has no effect. The gate keys are written once per run.
- R10: While reset is held, and afterwards until a start pulse, done is low and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a run from idle or done |
| bus_addr | output | AW | Transfer address |
| bus_wdata | output | 32 | Write data |
| bus_wr | output | 1 | Write request, held until ready |
| bus_rd | output | 1 | Read request, held until ready |
| bus_rdata | input | 32 | Read data, valid while ready is high during a read |
| bus_ready | input | 1 | Completes the current request at the clock edge |
| done | output | 1 | Sticky completion flag |

## Verification
A wrong table index or a stuck entry decode shows up at the first write after it: the scoreboard finds a mismatched address or value, or a write it did not expect. A delay counter that is off by even one cycle moves the next write's acceptance time, and every delay is timed against an exact expected gap. An error in layout decoding or in the merge appears only in the substitution write, so the runs vary the configuration field, bit 6 and the merge bits one at a time. A gate poll that accepts the wrong readback, or a start pulse that is not ignored, changes how many gate reads or key writes are counted in that run.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

  typedef enum logic [1:0] {K_WRITE, K_DELAY, K_SUBST, K_END} kind_e;
  typedef enum logic [1:0] {LAY_512X16, LAY_1GX16, LAY_512X32, LAY_1GX32} layout_e;

  typedef struct packed {
    kind_e       kind;
    logic [15:0] off;
    logic [31:0] val;
  } entry_t;

  localparam logic [31:0] GATE1_KEY = 32'h1688_A8A8;
  localparam logic [31:0] GATE2_KEY = 32'hFC60_0309;
  localparam logic [31:0] GATE_OPEN = 32'h0000_0001;

  function automatic layout_e decode_layout(input logic [31:0] cfg);
    layout_e l;
    unique case (cfg[3:2])
      2'd2:    l = cfg[6] ? LAY_1GX16 : LAY_512X32;
      2'd3:    l = LAY_1GX32;
      default: l = LAY_512X16;
    endcase
    return l;
  endfunction

  function automatic logic [31:0] subst_value(input layout_e l, input logic [31:0] tbl,
                                              input logic [31:0] merge);
    logic [31:0] base;
    case (l)
      LAY_1GX16: base = 32'h0000_0D89;
      LAY_1GX32: base = 32'h0000_0C8D;
      default:   base = tbl;
    endcase
    return base | {26'd0, merge[3:2], 4'd0};
  endfunction

endpackage

// File: rtl/init_seq_rom.sv
module init_seq_rom
  import init_seq_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic [IDXW-1:0] idx,
  output entry_t          ent
);
  always_comb begin
    ent = '{kind: K_END, off: 16'h0, val: 32'h0};
    case (int'(idx))
      0:  ent = '{kind: K_WRITE, off: 16'h0000, val: 32'h0A1B_2C3D};
      1:  ent = '{kind: K_WRITE, off: 16'h0040, val: 32'h00C0_FFEE};
      2:  ent = '{kind: K_DELAY, off: 16'h0000, val: 32'd2};
      3:  ent = '{kind: K_SUBST, off: 16'h0004, val: 32'h0000_0400};
      4:  ent = '{kind: K_WRITE, off: 16'h0018, val: 32'h1357_2468};
      5:  ent = '{kind: K_WRITE, off: 16'h0020, val: 32'h0000_BEEF};
      6:  ent = '{kind: K_DELAY, off: 16'h0000, val: 32'd1};
      7:  ent = '{kind: K_WRITE, off: 16'h0030, val: 32'h0000_0006};
      8:  ent = '{kind: K_WRITE, off: 16'h0030, val: 32'h0000_0002};
      9:  ent = '{kind: K_WRITE, off: 16'h0008, val: 32'h8000_0001};
      default: ent = '{kind: K_END, off: 16'h0, val: 32'h0};
    endcase
  end
endmodule

// File: rtl/init_seq_delay.sv
module init_seq_delay #(
  parameter int CYC_PER_US = 50,
  parameter int REPS       = 15,
  parameter int CW         = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] count_us,
  output logic          busy,
  output logic          fin
);
  localparam int CYCW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int REPW = (REPS > 1) ? $clog2(REPS) : 1;

  logic [CYCW-1:0] cyc_q;
  logic [CW-1:0]   us_q, cnt_q;
  logic [REPW-1:0] rep_q;
  logic            zero_q;
  logic            last_tick;

  assign last_tick = (cyc_q == '0) && (us_q == CW'(1)) && (rep_q == '0);
  assign fin       = busy && (zero_q || last_tick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      zero_q <= 1'b0;
      cyc_q  <= '0;
      us_q   <= '0;
      cnt_q  <= '0;
      rep_q  <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      zero_q <= (count_us == '0);
      cyc_q  <= CYCW'(CYC_PER_US - 1);
      us_q   <= count_us;
      cnt_q  <= count_us;
      rep_q  <= REPW'(REPS - 1);
    end else if (busy) begin
      if (fin) begin
        busy <= 1'b0;
      end else if (cyc_q == '0) begin
        cyc_q <= CYCW'(CYC_PER_US - 1);
        if (us_q == CW'(1)) begin
          us_q  <= cnt_q;
          rep_q <= rep_q - 1'b1;
        end else begin
          us_q <= us_q - 1'b1;
        end
      end else begin
        cyc_q <= cyc_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/init_seq_subst.sv
module init_seq_subst
  import init_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap,
  input  logic [31:0] cfg_word,
  input  logic [31:0] tbl_val,
  input  logic [31:0] merge_word,
  output layout_e     layout,
  output logic [31:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)   layout <= LAY_512X16;
    else if (cap) layout <= decode_layout(cfg_word);
  end

  assign value = subst_value(layout, tbl_val, merge_word);
endmodule

// File: rtl/init_seq.sv
module init_seq
  import init_seq_pkg::*;
#(
  parameter int          AW         = 20,
  parameter logic [31:0] BASE_ADDR  = 32'h0001_0000,
  parameter logic [31:0] GATE1_ADDR = 32'h0001_2000,
  parameter logic [31:0] GATE2_ADDR = 32'h0001_0000,
  parameter logic [31:0] CFG_ADDR   = 32'h0001_0004,
  parameter logic [31:0] MERGE_ADDR = 32'h0001_2070,
  parameter int          CYC_PER_US = 50,
  parameter int          DLY_REPS   = 15,
  parameter int          TBL_DEPTH  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  output logic          bus_wr,
  output logic          bus_rd,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ready,
  output logic          done
);
  localparam int IDXW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_G1_WR, S_G1_POLL, S_G2_WR, S_G2_POLL, S_CFG_RD,
    S_FETCH, S_ENT_WR, S_MRG_RD, S_DLY, S_DONE
  } state_e;

  state_e          state_q;
  logic [IDXW-1:0] idx_q;
  logic [15:0]     off_q;
  logic [31:0]     wdata_q, tval_q;
  entry_t          ent;
  logic [31:0]     sub_val;
  layout_e         layout;

  logic dly_busy, dly_fin, dly_load, cfg_cap, gate_ok, xfer;

  assign xfer     = (bus_wr || bus_rd) && bus_ready;
  assign gate_ok  = bus_ready && (bus_rdata == GATE_OPEN);
  assign cfg_cap  = (state_q == S_CFG_RD) && bus_ready;
  assign dly_load = (state_q == S_FETCH) && (ent.kind == K_DELAY);

  init_seq_rom #(.IDXW(IDXW)) u_rom (.idx(idx_q), .ent(ent));

  init_seq_delay #(.CYC_PER_US(CYC_PER_US), .REPS(DLY_REPS), .CW(16)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .count_us(ent.val[15:0]),
    .busy(dly_busy), .fin(dly_fin)
  );

  init_seq_subst u_sub (
    .clk(clk), .rst_n(rst_n), .cap(cfg_cap), .cfg_word(bus_rdata),
    .tbl_val(tval_q), .merge_word(bus_rdata), .layout(layout), .value(sub_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      off_q   <= '0;
      wdata_q <= '0;
      tval_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE, S_DONE: if (start) begin
          state_q <= S_G1_WR;
          idx_q   <= '0;
        end
        S_G1_WR:   if (bus_ready) state_q <= S_G1_POLL;
        S_G1_POLL: if (gate_ok)   state_q <= S_G2_WR;
        S_G2_WR:   if (bus_ready) state_q <= S_G2_POLL;
        S_G2_POLL: if (gate_ok)   state_q <= S_CFG_RD;
        S_CFG_RD:  if (bus_ready) state_q <= S_FETCH;
        S_FETCH: begin
          off_q <= ent.off;
          unique case (ent.kind)
            K_WRITE: begin wdata_q <= ent.val; state_q <= S_ENT_WR; end
            K_SUBST: begin tval_q  <= ent.val; state_q <= S_MRG_RD; end
            K_DELAY: state_q <= S_DLY;
            K_END:   state_q <= S_DONE;
          endcase
        end
        S_MRG_RD: if (bus_ready) begin
          wdata_q <= sub_val;
          state_q <= S_ENT_WR;
        end
        S_ENT_WR: if (bus_ready) begin
          idx_q   <= idx_q + 1'b1;
          state_q <= S_FETCH;
        end
        S_DLY: if (dly_fin) begin
          idx_q   <= idx_q + 1'b1;
          state_q <= S_FETCH;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = '0;
    bus_wdata = wdata_q;
    unique case (state_q)
      S_G1_WR:   begin bus_wr = 1'b1; bus_addr = AW'(GATE1_ADDR); bus_wdata = GATE1_KEY; end
      S_G1_POLL: begin bus_rd = 1'b1; bus_addr = AW'(GATE1_ADDR); end
      S_G2_WR:   begin bus_wr = 1'b1; bus_addr = AW'(GATE2_ADDR); bus_wdata = GATE2_KEY; end
      S_G2_POLL: begin bus_rd = 1'b1; bus_addr = AW'(GATE2_ADDR); end
      S_CFG_RD:  begin bus_rd = 1'b1; bus_addr = AW'(CFG_ADDR); end
      S_MRG_RD:  begin bus_rd = 1'b1; bus_addr = AW'(MERGE_ADDR); end
      S_ENT_WR:  begin bus_wr = 1'b1; bus_addr = AW'(BASE_ADDR + {16'd0, off_q}); end
      default: ;
    endcase
  end

  assign done = (state_q == S_DONE);

endmodule

module init_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          bus_ready,
  input logic          done,
  input logic          dly_busy
);
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_ready |=> bus_wr && $stable(bus_addr) && $stable(bus_wdata)); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_ready |=> bus_rd && $stable(bus_addr)); // R7
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)); // R7
  AST_DLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dly_busy |-> !bus_wr && !bus_rd); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_wr && !bus_rd); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R8
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> !done && bus_wr); // R1
endmodule

bind init_seq init_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_ready(bus_ready), .done(done), .dly_busy(dly_busy)
);

// File: tb/init_seq_test.sv
module init_seq_test;
  localparam int AW  = 20;
  localparam int CPU = 50;
  localparam logic [AW-1:0] B  = 20'h10000;
  localparam logic [AW-1:0] G1 = 20'h12000;
  localparam logic [AW-1:0] G2 = 20'h10000;
  localparam logic [AW-1:0] CF = 20'h10004;
  localparam logic [AW-1:0] MG = 20'h12070;
  localparam int N2 = 15 * 2 * CPU;
  localparam int N1 = 15 * 1 * CPU;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_wr, bus_rd, bus_ready, done;

  init_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .done(done)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bus responder
  int lat = 0, wcnt = 0, p1 = 0, p2 = 0;
  logic [31:0] cfg_val = '0, merge_val = '0;
  assign bus_ready = (bus_wr || bus_rd) && (wcnt >= lat);
  always_comb begin
    case (bus_addr)
      G1:      bus_rdata = (p1 == 0) ? 32'h0 : (p1 == 1) ? 32'h3 : 32'h1;
      CF:      bus_rdata = cfg_val;
      MG:      bus_rdata = merge_val;
      default: bus_rdata = 32'hDEAD_0000;
    endcase
    if (bus_addr == G2) bus_rdata = (p2 == 0) ? 32'h11 : 32'h1;
  end
  always @(posedge clk) begin
    if (bus_wr || bus_rd) begin
      if (bus_ready) begin
        wcnt <= 0;
        if (bus_wr && bus_addr == G1) p1 <= 0;
        if (bus_wr && bus_addr == G2 && bus_wdata == 32'hFC60_0309) p2 <= 0;
        if (bus_rd && bus_addr == G1) p1 <= p1 + 1;
        if (bus_rd && bus_addr == G2) p2 <= p2 + 1;
      end else wcnt <= wcnt + 1;
    end
  end

  // scoreboard
  typedef struct { logic [AW-1:0] a; logic [31:0] d; int gap; string req; } item_t;
  item_t expq[$];
  int last_wr = 0, n_rd_g1 = 0, n_rd_g2 = 0, n_key1 = 0, n_rd = 0;

  always @(negedge clk) begin
    if (rst_n && bus_ready && bus_rd) begin
      n_rd++;
      if (bus_addr == G1) n_rd_g1++;
      if (bus_addr == G2) n_rd_g2++;
    end
    if (rst_n && bus_ready && bus_wr) begin
      if (bus_addr == G1) n_key1++;
      if (expq.size() == 0) begin
        chk(1'b0, "R8", "unexpected write", {12'd0, bus_addr}, 32'h0);
      end else begin
        item_t it;
        it = expq.pop_front();
        chk(bus_addr == it.a, it.req, "write address", {12'd0, bus_addr}, {12'd0, it.a});
        chk(bus_wdata == it.d, it.req, "write data", bus_wdata, it.d);
        if (it.gap >= 0)
          chk((cyc - last_wr) == it.gap, it.req, "acceptance gap", cyc - last_wr, it.gap);
      end
      last_wr = cyc;
    end
  end

  task automatic push(input logic [AW-1:0] a, input logic [31:0] d, input int gap, input string req);
    item_t it;
    it.a = a; it.d = d; it.gap = gap; it.req = req;
    expq.push_back(it);
  endtask

  function automatic logic [31:0] exp_sub(input logic [31:0] cfg, input logic [31:0] mrg);
    logic [31:0] v;
    if (cfg[3] && cfg[2])      v = 32'hC8D;
    else if (cfg[3] && cfg[6]) v = 32'hD89;
    else                       v = 32'h400;
    return v | ((mrg & 32'hC) * 4);
  endfunction

  task automatic run(input logic [31:0] cfg, input logic [31:0] mrg, input int l, input bit poke);
    int b1, b2, bk, br;
    lat = l; cfg_val = cfg; merge_val = mrg;
    b1 = n_rd_g1; b2 = n_rd_g2; bk = n_key1;
    push(G1, 32'h1688_A8A8, -1, "R1");
    push(G2, 32'hFC60_0309, -1, "R1");
    push(B + 20'h0000, 32'h0A1B_2C3D, -1, "R3");
    push(B + 20'h0040, 32'h00C0_FFEE, 2 + l, "R3");
    push(B + 20'h0004, exp_sub(cfg, mrg), N2 + 4 + 2 * l, "R4 R5 R6 R2");
    push(B + 20'h0018, 32'h1357_2468, 2 + l, "R3");
    push(B + 20'h0020, 32'h0000_BEEF, 2 + l, "R3");
    push(B + 20'h0030, 32'h0000_0006, N1 + 3 + l, "R6");
    push(B + 20'h0030, 32'h0000_0002, 2 + l, "R3");
    push(B + 20'h0008, 32'h8000_0001, 2 + l, "R3");
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    chk(done == 1'b1, "R8", "done after end entry", {31'd0, done}, 32'h1);
    chk(expq.size() == 0, "R3", "writes left", expq.size(), 0);
    chk(n_rd_g1 - b1 == 3, "R1", "gate1 poll reads", n_rd_g1 - b1, 3);
    chk(n_rd_g2 - b2 == 2, "R1", "gate2 poll reads", n_rd_g2 - b2, 2);
    chk(n_key1 - bk == 1, "R9", "gate1 key writes", n_key1 - bk, 1);
    br = n_rd;
    repeat (25) @(negedge clk);
    chk(done == 1'b1, "R8", "done sticky", {31'd0, done}, 32'h1);
    chk(n_rd == br, "R8", "reads while done", n_rd - br, 0);
    while (expq.size() > 0) void'(expq.pop_front());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !bus_wr && !bus_rd, "R10", "reset outputs",
        {29'd0, done, bus_wr, bus_rd}, 32'h0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!done && !bus_wr && !bus_rd, "R10", "idle without start",
        {29'd0, done, bus_wr, bus_rd}, 32'h0);
    run(32'h0000_0000, 32'h0000_000C, 0, 1'b0);  // 512Mx16
    run(32'h0000_0048, 32'h0000_0004, 2, 1'b1);  // 1Gx16, start while busy (R9)
    run(32'h0000_0008, 32'hFFFF_FFF3, 1, 1'b0);  // 512Mx32, merge bits 3:2 clear
    run(32'h0000_000C, 32'h0000_0008, 0, 1'b0);  // 1Gx32
    run(32'h0000_0044, 32'h0000_0000, 3, 1'b0);  // field 1 with bit 6: 512Mx16
    run(32'h0000_004C, 32'h0000_000C, 1, 1'b0);  // field 3 with bit 6: 1Gx32
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule